// File: doc/BRIEF.md
# Partial Reconfiguration Host Engine

This block is the hardware side of a partial-reconfiguration session. A host sees it as a small window of 64-bit registers. Through that window the host resets the engine, opens a session for one target region, streams 32-bit configuration words, declares the push finished and collects the error causes. On its other side the engine feeds a word stream with valid and ready to a downstream loader. It tells the loader when the stream is finished and takes a done pulse and error pulses back from it.

Flow control is based on credits. The status register reports how many words the host may still push. Each accepted data write uses one credit, and each word the loader accepts returns one. The host detects that a session has finished when the engine clears the start bit by itself. Error causes stay latched until the host writes a one to them.

The controller is a six-state machine:
- IDLE (code 0) moves to LOAD on a control write with the start bit set.
- LOAD (2) moves to DRAIN on a control write with the push-complete bit set.
- DRAIN (3) moves to FINISH once the word queue is empty.
- FINISH (4) moves to WAITLD after one cycle.
- WAITLD (5) moves to IDLE on the loader's done pulse.
- Any state other than RHOLD moves to RHOLD (1) while the reset request is set. RHOLD moves to IDLE once the request is cleared.

The state code is visible as the controller status.

Top module: `recfg_host_engine`

## Requirements
- R1: After `rst_n` is released, the following all read 0: the status register (except credits = CREDIT_MAX in bits 8:0), host status (bits 27:24), controller status (bits 22:20), the control register and the error register.
- R2: The register map is as follows: offset 0x00 reads the FEATURE_HDR parameter, 0x08 is control, 0x10 is status, 0x18 is data and 0x20 is the error register. Offsets 0xA8 and 0xB0 read the low and high halves of the IFC_ID parameter. Any other offset reads 0. Control bits 63:32 read back as last written.
- R3: Writing control bit 0 = 1 puts the engine in RHOLD within two cycles. In RHOLD, control bit 4 (acknowledge) reads 1, host status is 1 and controller status is 1. RHOLD aborts any session, empties the queue and restores the credits to CREDIT_MAX. After bit 0 is written back to 0, host status returns to 0 and bit 4 to 0.
- R4: Each data write accepted in LOAD lowers the credit count (status bits 8:0) by one. Each word accepted downstream (`ld_valid` and `ld_ready` both high) raises it by one. The count never exceeds CREDIT_MAX.
- R5: In IDLE, a control write with bit 12 set opens a session. Bits 9:8 are latched as the region (driven on `ld_region`) and bit 14 as the image kind (driven on `ld_kind`). Control bit 12 then reads 1, and host status and controller status both read 2.
- R6: Data words (bits 31:0 of a write to 0x18) appear on `ld_word` in write order. `ld_valid` and `ld_word` are held until `ld_ready` accepts the word.
- R7: A control write with bit 13 set in LOAD ends the push. Once the queue is empty, `ld_finish` pulses for exactly one cycle and controller status reads 5. While the engine waits, control bits 12 and 13 read 1. An `ld_done` pulse then clears both bits and returns host status and controller status to 0.
- R8: Each `ld_err` bit latches into the same error cause bit, with the exception of bit 5, which is reserved and never set. Status bit 16 is the OR of the cause bits.
- R9: A data write outside LOAD sets cause bit 3 and pushes nothing: the credits are unchanged and `ld_valid` stays low.
- R10: A data write in LOAD with zero credits sets cause bit 4, and the word is dropped.
- R11: A write to the error register clears each cause bit whose matching bit 6:0 is 1. If a cause arrives in the same cycle as its clear, the cause wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 64 | Register write data |
| bus_rdata | output | 64 | Read data for `bus_addr` (combinational) |
| ld_valid | output | 1 | Word available to loader |
| ld_ready | input | 1 | Loader accepts word |
| ld_word | output | WORD_W | Configuration word |
| ld_region | output | 2 | Latched target region |
| ld_kind | output | 1 | Latched image kind |
| ld_finish | output | 1 | One-cycle end-of-stream pulse |
| ld_done | input | 1 | Loader completion pulse |
| ld_err | input | 7 | Loader error cause pulses |

## Verification
The word stream is exercised in four ways:
- The loader is stalled while the queue fills to zero credits. This separates the credit decrement from the overflow path.
- `ld_ready` alternates cycle by cycle. This shows that the word is held under back-pressure and that the order is kept.
- The loader runs free, which restores the credits.
- A session is aborted by a reset request while words are still queued. This separates the flush from a normal drain.

The error paths are covered by several cases:
- Data is written outside a session.
- Data is written with no credits left.
- The loader's pulses include the reserved bit.
- A clear is written in the same cycle as a new cause, which separates set priority from clear.

// File: rtl/recfg_pkg.sv
package recfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RHOLD  = 3'd1,
        ST_LOAD   = 3'd2,
        ST_DRAIN  = 3'd3,
        ST_FINISH = 3'd4,
        ST_WAITLD = 3'd5
    } eng_state_t;

    localparam logic [7:0] OFS_HDR = 8'h00;
    localparam logic [7:0] OFS_CTL = 8'h08;
    localparam logic [7:0] OFS_STS = 8'h10;
    localparam logic [7:0] OFS_DAT = 8'h18;
    localparam logic [7:0] OFS_ERR = 8'h20;
    localparam logic [7:0] OFS_IDL = 8'hA8;
    localparam logic [7:0] OFS_IDH = 8'hB0;

    localparam int NCAUSE   = 7;
    localparam int ERR_PROTO = 3;
    localparam int ERR_OVF   = 4;
    localparam logic [NCAUSE-1:0] CAUSE_MASK = 7'b101_1111;

    localparam int REGION_W = 2;
    localparam int CB_RST   = 0;
    localparam int CB_ACK   = 4;
    localparam int CB_REGLO = 8;
    localparam int CB_START = 12;
    localparam int CB_PUSH  = 13;
    localparam int CB_KIND  = 14;

    localparam int SB_FLAG  = 16;
    localparam int SB_CTRL  = 20;
    localparam int SB_HOST  = 24;
    localparam int CREDIT_FIELD_W = 9;

endpackage

// File: rtl/recfg_fsm.sv
module recfg_fsm
    import recfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_req,
    input  logic       start_cmd,
    input  logic       push_cmd,
    input  logic       q_empty,
    input  logic       ld_done,
    output logic       sess_begin,
    output logic       flush,
    output logic       in_load,
    output logic       start_bit,
    output logic       push_bit,
    output logic       ack,
    output logic       finish_pulse,
    output logic [3:0] host_status,
    output logic [2:0] ctrl_status
);

    eng_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (rst_req && state_q != ST_RHOLD) begin
            state_d = ST_RHOLD;
        end else begin
            unique case (state_q)
                ST_RHOLD:  if (!rst_req)   state_d = ST_IDLE;
                ST_IDLE:   if (start_cmd)  state_d = ST_LOAD;
                ST_LOAD:   if (push_cmd)   state_d = ST_DRAIN;
                ST_DRAIN:  if (q_empty)    state_d = ST_FINISH;
                ST_FINISH:                 state_d = ST_WAITLD;
                ST_WAITLD: if (ld_done)    state_d = ST_IDLE;
                default:                   state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sess_begin   = 1'b0;
        flush        = 1'b0;
        in_load      = 1'b0;
        start_bit    = 1'b0;
        push_bit     = 1'b0;
        ack          = 1'b0;
        finish_pulse = 1'b0;
        host_status  = 4'd2;
        ctrl_status  = state_q;
        unique case (state_q)
            ST_IDLE: begin
                host_status = 4'd0;
                sess_begin  = start_cmd && !rst_req;
            end
            ST_RHOLD: begin
                host_status = 4'd1;
                flush       = 1'b1;
                ack         = 1'b1;
            end
            ST_LOAD: begin
                in_load   = 1'b1;
                start_bit = 1'b1;
            end
            ST_DRAIN, ST_WAITLD: begin
                start_bit = 1'b1;
                push_bit  = 1'b1;
            end
            ST_FINISH: begin
                start_bit    = 1'b1;
                push_bit     = 1'b1;
                finish_pulse = 1'b1;
            end
            default: host_status = 4'd0;
        endcase
    end

    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RHOLD && !rst_req) |=> (host_status == 4'd0 && !ack));

    a_r5_begin: assert property (@(posedge clk) disable iff (!rst_n)
        sess_begin |=> (start_bit && in_load));

    a_r7_finish_once: assert property (@(posedge clk) disable iff (!rst_n)
        finish_pulse |=> !finish_pulse);

    a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAITLD && ld_done && !rst_req) |=>
            (!start_bit && !push_bit && host_status == 4'd0));

endmodule

// File: rtl/recfg_word_queue.sv
module recfg_word_queue #(
    parameter int DEPTH  = 256,
    parameter int WORD_W = 32,
    parameter int CRED_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic [CRED_W-1:0] credits,
    output logic              empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CRED_W-1:0] ONE_C  = CRED_W'(1);
    localparam logic [CRED_W-1:0] FULL_C = CRED_W'(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CRED_W-1:0] occ_q, cred_q;
    logic              pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign out_valid = (occ_q != '0);
    assign empty     = (occ_q == '0);
    assign out_word  = mem[rd_ptr];
    assign credits   = cred_q;
    assign pop       = out_valid && pop_ready;

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= push_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ_q  <= '0;
            cred_q <= FULL_C;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ_q  <= '0;
            cred_q <= FULL_C;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            unique case ({push, pop})
                2'b10: begin
                    occ_q  <= occ_q + ONE_C;
                    cred_q <= cred_q - ONE_C;
                end
                2'b01: begin
                    occ_q  <= occ_q - ONE_C;
                    cred_q <= cred_q + ONE_C;
                end
                default: ;
            endcase
        end
    end

    a_r4_credit_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cred_q <= FULL_C);

    a_r4_credit_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cred_q) + int'(occ_q)) == DEPTH);

    a_r4_pop_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush) |=> (cred_q == $past(cred_q) + ONE_C));

    a_r10_no_push_empty_credit: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cred_q != '0));

endmodule

// File: rtl/recfg_err_log.sv
module recfg_err_log #(
    parameter int NC = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_wr,
    input  logic [NC-1:0] clr_mask,
    input  logic [NC-1:0] set_vec,
    output logic [NC-1:0] causes,
    output logic          any_err
);

    logic [NC-1:0] causes_q;
    logic [NC-1:0] clr_eff;

    assign clr_eff = clr_wr ? clr_mask : '0;
    assign causes  = causes_q;
    assign any_err = |causes_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) causes_q <= '0;
        else        causes_q <= (causes_q & ~clr_eff) | set_vec;
    end

    a_r11_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((causes_q & $past(clr_mask & ~set_vec)) == '0));

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((causes_q & $past(set_vec)) == $past(set_vec)));

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((causes_q & $past(causes_q)) == $past(causes_q)));

endmodule

// File: rtl/recfg_host_engine.sv
module recfg_host_engine
    import recfg_pkg::*;
#(
    parameter int           CREDIT_MAX  = 256,
    parameter int           ADDR_W      = 8,
    parameter int           WORD_W      = 32,
    parameter logic [63:0]  FEATURE_HDR = 64'h3000_0000_1000_0005,
    parameter logic [127:0] IFC_ID      = 128'h5a1e_77c3_0b9d_4f12_8e60_2c4a_91d7_e3b8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [63:0]         bus_wdata,
    output logic [63:0]         bus_rdata,
    output logic                ld_valid,
    input  logic                ld_ready,
    output logic [WORD_W-1:0]   ld_word,
    output logic [REGION_W-1:0] ld_region,
    output logic                ld_kind,
    output logic                ld_finish,
    input  logic                ld_done,
    input  logic [NCAUSE-1:0]   ld_err
);

    localparam int CRED_W = $clog2(CREDIT_MAX + 1);
    localparam logic [ADDR_W-1:0] A_HDR = ADDR_W'(OFS_HDR);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(OFS_DAT);
    localparam logic [ADDR_W-1:0] A_ERR = ADDR_W'(OFS_ERR);
    localparam logic [ADDR_W-1:0] A_IDL = ADDR_W'(OFS_IDL);
    localparam logic [ADDR_W-1:0] A_IDH = ADDR_W'(OFS_IDH);

    logic                ctl_wr, dat_wr, err_wr;
    logic                rst_req_q;
    logic [31:0]         cfg_q;
    logic [REGION_W-1:0] region_q;
    logic                kind_q;

    logic sess_begin, flush, in_load, start_bit, push_bit, ack;
    logic [3:0] host_status;
    logic [2:0] ctrl_status;

    logic              q_push, q_empty;
    logic [CRED_W-1:0] credits;
    logic              proto_hit, ovf_hit;
    logic [NCAUSE-1:0] err_set, err_causes;
    logic              any_err;
    logic [63:0]       ctl_rd, sts_rd;

    assign ctl_wr = bus_wr && (bus_addr == A_CTL);
    assign dat_wr = bus_wr && (bus_addr == A_DAT);
    assign err_wr = bus_wr && (bus_addr == A_ERR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
            cfg_q     <= '0;
            region_q  <= '0;
            kind_q    <= 1'b0;
        end else begin
            if (ctl_wr) begin
                rst_req_q <= bus_wdata[CB_RST];
                cfg_q     <= bus_wdata[63:32];
            end
            if (sess_begin) begin
                region_q <= bus_wdata[CB_REGLO +: REGION_W];
                kind_q   <= bus_wdata[CB_KIND];
            end
        end
    end

    recfg_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rst_req      (rst_req_q),
        .start_cmd    (ctl_wr && bus_wdata[CB_START]),
        .push_cmd     (ctl_wr && bus_wdata[CB_PUSH]),
        .q_empty      (q_empty),
        .ld_done      (ld_done),
        .sess_begin   (sess_begin),
        .flush        (flush),
        .in_load      (in_load),
        .start_bit    (start_bit),
        .push_bit     (push_bit),
        .ack          (ack),
        .finish_pulse (ld_finish),
        .host_status  (host_status),
        .ctrl_status  (ctrl_status)
    );

    assign q_push    = dat_wr && in_load && (credits != '0);
    assign proto_hit = dat_wr && !in_load;
    assign ovf_hit   = dat_wr && in_load && (credits == '0);

    recfg_word_queue #(
        .DEPTH  (CREDIT_MAX),
        .WORD_W (WORD_W),
        .CRED_W (CRED_W)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (q_push),
        .push_word (bus_wdata[WORD_W-1:0]),
        .pop_ready (ld_ready),
        .out_valid (ld_valid),
        .out_word  (ld_word),
        .credits   (credits),
        .empty     (q_empty)
    );

    always_comb begin
        err_set            = ld_err & CAUSE_MASK;
        err_set[ERR_PROTO] = err_set[ERR_PROTO] | proto_hit;
        err_set[ERR_OVF]   = err_set[ERR_OVF] | ovf_hit;
    end

    recfg_err_log #(.NC(NCAUSE)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_wr   (err_wr),
        .clr_mask (bus_wdata[NCAUSE-1:0]),
        .set_vec  (err_set),
        .causes   (err_causes),
        .any_err  (any_err)
    );

    assign ld_region = region_q;
    assign ld_kind   = kind_q;

    always_comb begin
        ctl_rd                       = '0;
        ctl_rd[63:32]                = cfg_q;
        ctl_rd[CB_KIND]              = kind_q;
        ctl_rd[CB_PUSH]              = push_bit;
        ctl_rd[CB_START]             = start_bit;
        ctl_rd[CB_REGLO +: REGION_W] = region_q;
        ctl_rd[CB_ACK]               = ack;
        ctl_rd[CB_RST]               = rst_req_q;

        sts_rd                         = '0;
        sts_rd[CREDIT_FIELD_W-1:0]     = CREDIT_FIELD_W'(credits);
        sts_rd[SB_FLAG]                = any_err;
        sts_rd[SB_CTRL +: 3]           = ctrl_status;
        sts_rd[SB_HOST +: 4]           = host_status;
    end

    always_comb begin
        unique case (bus_addr)
            A_HDR:   bus_rdata = FEATURE_HDR;
            A_CTL:   bus_rdata = ctl_rd;
            A_STS:   bus_rdata = sts_rd;
            A_ERR:   bus_rdata = {{(64-NCAUSE){1'b0}}, err_causes};
            A_IDL:   bus_rdata = IFC_ID[63:0];
            A_IDH:   bus_rdata = IFC_ID[127:64];
            default: bus_rdata = '0;
        endcase
    end

    a_r9_proto: assert property (@(posedge clk) disable iff (!rst_n)
        proto_hit |=> err_causes[ERR_PROTO]);

    a_r10_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_hit |=> err_causes[ERR_OVF]);

    a_r8_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !err_causes[5]);

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_ready && !flush) |=> (ld_valid && $stable(ld_word)));

endmodule

// File: tb/tb_recfg_host_engine.sv
module tb_recfg_host_engine;

    localparam int CLK_NS = 10;
    localparam int DEPTH  = 4;
    localparam logic [63:0]  HDR = 64'h0123_4567_89AB_CDEF;
    localparam logic [127:0] IID = 128'hFEED_0001_0002_0003_0004_0005_0006_0007;
    localparam logic [7:0] A_CTL = 8'h08, A_STS = 8'h10, A_DAT = 8'h18, A_ERR = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        ld_valid, ld_kind, ld_finish;
    logic        ld_ready = 1'b0;
    logic [31:0] ld_word;
    logic [1:0]  ld_region;
    logic        ld_done = 1'b0;
    logic [6:0]  ld_err = '0;

    recfg_host_engine #(
        .CREDIT_MAX (DEPTH), .ADDR_W (8), .WORD_W (32),
        .FEATURE_HDR (HDR), .IFC_ID (IID)
    ) dut (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .ld_valid (ld_valid),
        .ld_ready (ld_ready), .ld_word (ld_word), .ld_region (ld_region),
        .ld_kind (ld_kind), .ld_finish (ld_finish), .ld_done (ld_done),
        .ld_err (ld_err)
    );

    always #(CLK_NS/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int          m_st = 0;
    bit          m_rreq = 0;
    logic [31:0] m_q[$];
    int          m_cred = DEPTH;
    logic [6:0]  m_err = '0;
    logic [1:0]  m_region = '0;
    bit          m_kind = 0;
    logic [31:0] m_cfg = '0;
    logic [31:0] got[$];
    int          fin_cnt = 0;

    always @(posedge clk) begin
        bit pop, dat, ctl, errw, pre_empty, push_ok;
        logic [6:0] nerr;
        if (!rst_n) begin
            m_st = 0; m_rreq = 0; m_q.delete(); m_cred = DEPTH; m_err = '0;
            m_region = '0; m_kind = 0; m_cfg = '0;
        end else begin
            if (ld_valid && ld_ready) got.push_back(ld_word);
            if (ld_finish) fin_cnt++;
            pop       = (m_q.size() > 0) && ld_ready;
            pre_empty = (m_q.size() == 0);
            ctl  = bus_wr && bus_addr == A_CTL;
            dat  = bus_wr && bus_addr == A_DAT;
            errw = bus_wr && bus_addr == A_ERR;
            push_ok = dat && m_st == 2 && m_cred != 0;
            nerr = ld_err & 7'b101_1111;
            if (dat && m_st != 2) nerr[3] = 1'b1;
            if (dat && m_st == 2 && m_cred == 0) nerr[4] = 1'b1;
            m_err = (m_err & ~(errw ? bus_wdata[6:0] : 7'd0)) | nerr;
            if (m_st == 1) begin
                m_q.delete(); m_cred = DEPTH;
            end else begin
                if (pop) begin void'(m_q.pop_front()); m_cred++; end
                if (push_ok) begin m_q.push_back(bus_wdata[31:0]); m_cred--; end
            end
            if (m_rreq && m_st != 1) m_st = 1;
            else case (m_st)
                1: if (!m_rreq) m_st = 0;
                0: if (ctl && bus_wdata[12]) begin
                       m_st = 2; m_region = bus_wdata[9:8]; m_kind = bus_wdata[14];
                   end
                2: if (ctl && bus_wdata[13]) m_st = 3;
                3: if (pre_empty) m_st = 4;
                4: m_st = 5;
                5: if (ld_done) m_st = 0;
                default: m_st = 0;
            endcase
            if (ctl) begin m_rreq = bus_wdata[0]; m_cfg = bus_wdata[63:32]; end
        end
        #2;
        if (rst_n) begin
            chk("R6 ld_valid vs model", {63'd0, ld_valid}, {63'd0, m_q.size() > 0});
            if (m_q.size() > 0) chk("R6 ld_word vs model", {32'd0, ld_word}, {32'd0, m_q[0]});
            chk("R7 ld_finish vs model", {63'd0, ld_finish}, {63'd0, m_st == 4});
            chk("R5 region/kind vs model", {61'd0, ld_kind, ld_region}, {61'd0, m_kind, m_region});
        end
    end

    function automatic logic [63:0] exp_sts();
        logic [63:0] v = '0;
        v[8:0]   = 9'(m_cred);
        v[16]    = |m_err;
        v[22:20] = 3'(m_st);
        v[27:24] = (m_st == 0) ? 4'd0 : (m_st == 1) ? 4'd1 : 4'd2;
        return v;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        #(CLK_NS * 50000);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        cyc(3);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_STS, d); chk("R1 status after reset", d, 64'h0000_0000_0000_0004);
        rd(A_CTL, d); chk("R1 control after reset", d, 64'd0);
        rd(A_ERR, d); chk("R1 errors after reset", d, 64'd0);

        // R2 register map
        rd(8'h00, d); chk("R2 header", d, HDR);
        rd(8'hA8, d); chk("R2 id low", d, IID[63:0]);
        rd(8'hB0, d); chk("R2 id high", d, IID[127:64]);
        rd(8'h28, d); chk("R2 reserved word", d, 64'd0);
        rd(8'h98, d); chk("R2 reserved word", d, 64'd0);

        // R3 reset handshake
        wr(A_CTL, 64'h1); cyc(2);
        rd(A_CTL, d); chk("R3 ack set", d, 64'h11);
        rd(A_STS, d); chk("R3 host/ctrl in hold", d, 64'h0110_0004);
        wr(A_CTL, 64'h0); cyc(2);
        rd(A_STS, d); chk("R3 host idle after release", d, 64'h4);
        rd(A_CTL, d); chk("R3 ack cleared", d, 64'h0);

        // R9 data write outside a session
        wr(A_DAT, 64'h1234); cyc(1);
        rd(A_ERR, d); chk("R9 protocol cause", d, 64'h08);
        rd(A_STS, d); chk("R9 credits unchanged, flag set", d, 64'h0001_0004);
        chk("R9 nothing queued", {63'd0, ld_valid}, 64'd0);
        wr(A_ERR, 64'h08); cyc(1);
        rd(A_ERR, d); chk("R11 clear protocol cause", d, 64'h0);

        // R5 session start, region 2, kind 1
        wr(A_CTL, 64'hCAFE_0001_0000_5200); cyc(1);
        chk("R5 ld_region", {62'd0, ld_region}, 64'd2);
        chk("R5 ld_kind", {63'd0, ld_kind}, 64'd1);
        rd(A_CTL, d); chk("R5 control readback", d, 64'hCAFE_0001_0000_5200);
        rd(A_STS, d); chk("R5 status in load", d, 64'h0220_0004);

        // R4 credit decrement with stalled loader
        wr(A_DAT, 64'hA0); wr(A_DAT, 64'hA1); wr(A_DAT, 64'hA2); cyc(1);
        rd(A_STS, d); chk("R4 credits after three", d, 64'h0220_0001);
        chk("R6 head word held", {32'd0, ld_word}, 64'hA0);
        wr(A_DAT, 64'hA3);
        wr(A_DAT, 64'hA4); cyc(1);
        rd(A_ERR, d); chk("R10 overflow cause", d, 64'h10);
        rd(A_STS, d); chk("R10 zero credits with flag", d, 64'h0221_0000);
        wr(A_ERR, 64'h7F);

        // R6 alternating back-pressure, then free run
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); ld_ready = i[0];
        end
        @(negedge clk); ld_ready = 1'b1;
        cyc(4);
        chk("R6 accepted count", 64'(got.size()), 64'd4);
        for (int i = 0; i < 4; i++)
            if (i < got.size()) chk("R6 word order", {32'd0, got[i]}, 64'(32'hA0 + i));
        rd(A_STS, d); chk("R4 credits restored", d, 64'h0220_0004);

        // R7 push complete and done
        wr(A_CTL, 64'hCAFE_0001_0000_7200); cyc(4);
        chk("R7 single finish pulse", 64'(fin_cnt), 64'd1);
        rd(A_CTL, d); chk("R7 start/push held while waiting", d, 64'hCAFE_0001_0000_7200);
        rd(A_STS, d); chk("R7 waiting status", d, 64'h0250_0004);
        @(negedge clk); ld_done = 1'b1; ld_err = 7'h26;
        @(negedge clk); ld_done = 1'b0; ld_err = '0;
        rd(A_CTL, d); chk("R7 start/push cleared", d, 64'hCAFE_0001_0000_4200);
        rd(A_STS, d); chk("R8 idle with error flag", d, 64'h0001_0004);
        rd(A_ERR, d); chk("R8 loader causes, reserved dropped", d, 64'h06);

        // R11 write-one-to-clear
        wr(A_ERR, 64'h02);
        rd(A_ERR, d); chk("R11 partial clear", d, 64'h04);
        @(negedge clk); bus_wr = 1'b1; bus_addr = A_ERR; bus_wdata = 64'h02; ld_err = 7'h02;
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0; ld_err = '0;
        rd(A_ERR, d); chk("R11 set wins over clear", d, 64'h06);
        wr(A_ERR, 64'h7F);
        rd(A_STS, d); chk("R8 flag drops with causes", d, 64'h4);

        // R3 abort during a session
        ld_ready = 1'b0;
        wr(A_CTL, 64'h1100); wr(A_DAT, 64'hB0); wr(A_DAT, 64'hB1); cyc(1);
        chk("R3 words queued before abort", {63'd0, ld_valid}, 64'd1);
        wr(A_CTL, 64'h1); cyc(3);
        chk("R3 queue emptied", {63'd0, ld_valid}, 64'd0);
        rd(A_STS, d); chk("R3 credits restored in hold", d, 64'h0110_0004);
        rd(A_CTL, d); chk("R3 start cleared on abort", d, 64'h111);
        wr(A_CTL, 64'h0); cyc(2);
        rd(A_STS, d); chk("R3 idle after abort", d, exp_sts());
        chk("R1 model idle", 64'(m_st), 64'd0);

        ld_ready = 1'b1;
        cyc(2);
        finished = 1;
        summary();
        $finish;
    end

endmodule